// File: doc/BRIEF.md
# I2C Clock Tick Generator

This block derives the serial-clock timing for an I2C master from the system clock. Two programmable stages and a fixed stage are chained. The first stage divides the clock by A+1. The second divides the first stage's wrap pulses by B+1. Each wrap of the second stage is one base unit. A final counter of 22 units makes up one serial-clock period.

The period is split into four phases of 6, 5, 6 and 5 units. The two halves are therefore exactly 11 units each. A single-cycle tick marks the entry into each phase. The bit engine uses these ticks to place START, STOP, data setup and sampling. A free-running serial-clock reference is low in the first half of each period and high in the second half.

Software chooses A and B so that the resulting rate stays at or below the fast-mode limit. The block only uses the values it is given. A divisor change is held back until the current period ends. While the enable input is low, every counter is held at zero and the outputs stay idle.

Top module: `scl_tick_gen`

## Requirements
- R1: While rst_ni is low, and in every cycle that follows an edge at which en_i was sampled low, phase_tick_o is 0, phase_o is 0 and scl_ref_o is 1.
- R2: One base unit lasts T = (A+1)·(B+1) clock cycles. A is div_a_i (2 bits) and B is div_b_i (6 bits). One serial-clock period lasts 22·T cycles.
- R3: At the first edge at which en_i is sampled high after being low, the outputs show phase_tick_o = 1, phase_o = 0 and scl_ref_o = 0 from that edge on.
- R4: After enable, phase_o steps 0, 1, 2, 3 and back to 0. The phases last 6·T, 5·T, 6·T and 5·T cycles. phase_tick_o is high for exactly one cycle each time a phase is entered, including the wrap to phase 0.
- R5: scl_ref_o is 0 in phases 0 and 1 and is 1 in phases 2 and 3.
- R6: The divisors are captured on the first enabled edge and at each wrap to phase 0. A change of div_a_i or div_b_i during a period leaves the rest of that period unchanged and takes effect from the next period.
- R7: Dropping en_i returns the outputs to the R1 state at the next edge. Raising it again restarts the sequence at phase 0 as in R3.
- R8: The extreme settings A=0, B=0 (T=1) and A=3, B=63 (T=256) follow R2 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Runs the tick generator while high |
| div_a_i | input | 2 | First-stage divisor A (divides by A+1) |
| div_b_i | input | 6 | Second-stage divisor B (divides by B+1) |
| phase_tick_o | output | 1 | One-cycle pulse on entry into each phase |
| phase_o | output | 2 | Current quarter phase, 0 to 3 |
| scl_ref_o | output | 1 | Serial-clock reference, low in the first half |

## Verification
Every result is registered, so each one is due one edge after the stimulus that causes it. The first tick follows the enable edge by one edge. Each later tick comes 6·T or 5·T edges after the previous one. The idle state follows a low enable by one edge. The bench drives and samples on falling edges. It counts falling edges between consecutive ticks and compares each count with 6·T or 5·T, computed from the divisors that are in force for that period. Phase and reference values are read on the same falling edge as the tick, and a divisor change is always made just after a tick so that the period it falls in is known.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int unsigned DIV_A_W    = 2;
  localparam int unsigned DIV_B_W    = 6;
  localparam int unsigned BIT_UNITS  = 22;
  localparam int unsigned UNIT_W     = $clog2(BIT_UNITS);
  localparam int unsigned HALF_UNITS = BIT_UNITS / 2;
  localparam int unsigned Q1_UNITS   = (HALF_UNITS + 1) / 2;
  localparam int unsigned Q3_UNITS   = HALF_UNITS + Q1_UNITS;

  typedef enum logic [1:0] {
    PH_LOW_A  = 2'd0,
    PH_LOW_B  = 2'd1,
    PH_HIGH_A = 2'd2,
    PH_HIGH_B = 2'd3
  } phase_e;
endpackage

// File: rtl/scl_div_stage.sv
module scl_div_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == limit_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  // R2: the count never passes the divisor in force
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i);

  // R2: a wrap restarts the count at zero
  p_wrap_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_div_pkg::*;
#(
  parameter int unsigned UNITS = BIT_UNITS,
  parameter int unsigned UW    = $clog2(UNITS)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       start_i,
  input  logic       run_i,
  input  logic       unit_i,
  output logic [1:0] phase_o,
  output logic       scl_o,
  output logic       tick_o,
  output logic       last_o
);
  localparam int unsigned HALF = UNITS / 2;
  localparam int unsigned Q1   = (HALF + 1) / 2;
  localparam int unsigned Q3   = HALF + Q1;
  localparam logic [UW-1:0] LIM_C  = UW'(UNITS - 1);
  localparam logic [UW-1:0] Q1_C   = UW'(Q1);
  localparam logic [UW-1:0] HALF_C = UW'(HALF);
  localparam logic [UW-1:0] Q3_C   = UW'(Q3);

  logic [UW-1:0] cnt;
  logic          wrap;
  logic          boundary;
  logic          tick_q;
  phase_e        phase;

  scl_div_stage #(.W(UW)) u_unit_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .step_i (unit_i),
    .limit_i(LIM_C),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  always_comb begin
    if (cnt < Q1_C)        phase = PH_LOW_A;
    else if (cnt < HALF_C) phase = PH_LOW_B;
    else if (cnt < Q3_C)   phase = PH_HIGH_A;
    else                   phase = PH_HIGH_B;
  end

  // last unit of a phase: the next unit enters a new one
  assign boundary = (cnt == Q1_C - 1'b1) || (cnt == HALF_C - 1'b1) ||
                    (cnt == Q3_C - 1'b1) || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= en_i && (start_i || (unit_i && boundary));
  end

  assign phase_o = phase;
  assign scl_o   = !run_i || (cnt >= HALF_C);
  assign tick_o  = tick_q;
  assign last_o  = wrap;

  // R4: ticks are single-cycle
  p_tick_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R4: every phase change while running is marked by a tick
  p_phase_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && (phase_o != $past(phase_o))) |-> tick_o);

  // R5: reference low in the first half, high in the second
  p_scl_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (scl_o == phase_o[1]));
endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen
  import scl_div_pkg::*;
#(
  parameter int unsigned A_W   = DIV_A_W,
  parameter int unsigned B_W   = DIV_B_W,
  parameter int unsigned UNITS = BIT_UNITS
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [A_W-1:0] div_a_i,
  input  logic [B_W-1:0] div_b_i,
  output logic           phase_tick_o,
  output logic [1:0]     phase_o,
  output logic           scl_ref_o
);
  localparam int unsigned UW = $clog2(UNITS);

  logic           run_q;
  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  logic           clr;
  logic           active;
  logic           load;
  logic           a_wrap;
  logic           unit;
  logic           period_last;
  logic [A_W-1:0] a_cnt;
  logic [B_W-1:0] b_cnt;

  assign clr    = !en_i || !run_q;
  assign active = en_i && run_q;
  assign load   = !run_q || period_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      a_q   <= '0;
      b_q   <= '0;
    end else begin
      run_q <= en_i;
      if (load) begin
        a_q <= div_a_i;
        b_q <= div_b_i;
      end
    end
  end

  scl_div_stage #(.W(A_W)) u_stage_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (active),
    .limit_i(a_q),
    .cnt_o  (a_cnt),
    .wrap_o (a_wrap)
  );

  scl_div_stage #(.W(B_W)) u_stage_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (a_wrap),
    .limit_i(b_q),
    .cnt_o  (b_cnt),
    .wrap_o (unit)
  );

  scl_phase_seq #(.UNITS(UNITS), .UW(UW)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (en_i),
    .start_i(!run_q),
    .run_i  (run_q),
    .unit_i (unit),
    .phase_o(phase_o),
    .scl_o  (scl_ref_o),
    .tick_o (phase_tick_o),
    .last_o (period_last)
  );

  // R1: low enable idles every output at the next edge
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!phase_tick_o && scl_ref_o && (phase_o == 2'd0)));

  // R3: first enabled edge opens phase 0 with a tick
  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !run_q) |=> (phase_tick_o && (phase_o == 2'd0) && !scl_ref_o));

  // R6: divisors held inside a running period
  p_div_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !period_last) |=> ($stable(a_q) && $stable(b_q)));

  // R6: a period wrap restarts both prescale stages together
  p_wrap_aligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_last |=> ((a_cnt == '0) && (b_cnt == '0)));
endmodule

// File: tb/tb_scl_tick_gen.sv
module tb_scl_tick_gen;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] div_a_i = '0;
  logic [5:0] div_b_i = '0;
  logic       phase_tick_o;
  logic [1:0] phase_o;
  logic       scl_ref_o;

  int checks = 0;
  int fails  = 0;

  scl_tick_gen dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .div_a_i     (div_a_i),
    .div_b_i     (div_b_i),
    .phase_tick_o(phase_tick_o),
    .phase_o     (phase_o),
    .scl_ref_o   (scl_ref_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts falling edges until a tick is seen
  task automatic wait_tick(output int n, input int limit);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!phase_tick_o && n < limit);
  endtask

  task automatic chk_idle(input string req);
    chk({req, " tick"}, int'(phase_tick_o), 0);
    chk({req, " phase"}, int'(phase_o), 0);
    chk({req, " scl"}, int'(scl_ref_o), 1);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk_idle("R1 in reset");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk_idle("R1 disabled");
  endtask

  // full period with fixed divisors; R2/R4/R5/R8
  task automatic t_rate(input int a, input int b, input string tag);
    int t, n;
    int gap[4] = '{6, 5, 6, 5};
    t = (a + 1) * (b + 1);
    div_a_i = 2'(a);
    div_b_i = 6'(b);
    en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    en_i = 1'b1;
    wait_tick(n, 4);
    chk({tag, " R3 first tick"}, n, 1);
    chk({tag, " R3 phase"}, int'(phase_o), 0);
    chk({tag, " R3 scl"}, int'(scl_ref_o), 0);
    for (int k = 1; k <= 4; k++) begin
      wait_tick(n, 8 * t + 8);
      chk({tag, " R2 R4 gap"}, n, gap[k-1] * t);
      chk({tag, " R4 phase"}, int'(phase_o), k % 4);
      chk({tag, " R5 scl"}, int'(scl_ref_o), (k == 2 || k == 3) ? 1 : 0);
    end
    @(negedge clk_i);
    chk({tag, " R4 tick width"}, int'(phase_tick_o), 0);
    en_i = 1'b0;
    @(negedge clk_i);
    chk_idle({tag, " R1 after stop"});
  endtask

  // divisor change mid-period
  task automatic t_retime();
    int n;
    int gap[4] = '{12, 10, 12, 10};
    div_a_i = 2'd0;
    div_b_i = 6'd1;
    repeat (2) @(negedge clk_i);
    en_i = 1'b1;
    wait_tick(n, 4);
    chk("R6 first tick", n, 1);
    div_a_i = 2'd1;
    div_b_i = 6'd2;
    for (int k = 0; k < 4; k++) begin
      wait_tick(n, 200);
      chk("R6 old divisor kept", n, gap[k]);
    end
    wait_tick(n, 400);
    chk("R6 new divisor next period", n, 36);
    chk("R6 phase", int'(phase_o), 1);
    en_i = 1'b0;
    @(negedge clk_i);
  endtask

  // enable dropped mid-period, then restarted
  task automatic t_restart();
    int n;
    int seen;
    div_a_i = 2'd0;
    div_b_i = 6'd0;
    @(negedge clk_i);
    en_i = 1'b1;
    wait_tick(n, 4);
    repeat (8) @(negedge clk_i);
    chk("R7 mid phase", int'(phase_o), 1);
    en_i = 1'b0;
    @(negedge clk_i);
    chk_idle("R7 stop");
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      if (phase_tick_o) seen++;
    end
    chk("R7 no ticks while stopped", seen, 0);
    en_i = 1'b1;
    wait_tick(n, 4);
    chk("R7 restart tick", n, 1);
    chk("R7 restart phase", int'(phase_o), 0);
    chk("R7 restart scl", int'(scl_ref_o), 0);
    wait_tick(n, 20);
    chk("R7 first gap", n, 6);
    en_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    t_reset();
    t_rate(0, 0, "R8 min");
    t_rate(2, 4, "mid");
    t_rate(1, 9, "odd");
    t_retime();
    t_restart();
    t_rate(3, 63, "R8 max");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule